// File: doc/BRIEF.md
# Asynchronous External Bus Master

This block sits between a processor-side request port and an asynchronous parallel bus. It takes one word per request, given as a byte address, write data and a read/write flag. It then runs a complete external bus cycle on the pins: chip select, write strobe, read strobe, word address and a 32-bit data bus. When the cycle is done it returns a one-clock acknowledge, which carries the read data for reads.

A cycle has three phases. The setup clock drives chip select, the address and, for writes, the data. The strobe phase then lasts a programmable number of clocks. Last comes one hold clock. Only requests whose upper nibble selects the external region produce pin activity. Any other request is acknowledged straight away and leaves the bus quiet.

The request side follows valid/ready rules. `req_ready` is high only while the block is idle. A requester must hold `req_valid` and its payload stable until a clock edge where both are high. That edge accepts the request, and ready then stays low until the acknowledge has been given. The response side has no back-pressure: `rsp_valid` is a single-clock pulse that the requester must take when it appears.

Top module: `ebm_bus_master`

## Requirements
- R1: A request with byte-address bits 31:28 equal to 4'hA runs an external cycle. Any other request drives no strobe and leaves `ext_cs_n` high. It is acknowledged on the clock right after acceptance with `rsp_rdata` zero.
- R2: `ext_addr` equals byte-address bits 21:2 of the request. It is held stable for every clock in which `ext_cs_n` is low.
- R3: In a write, `ext_cs_n` is low, `ext_wdata_en` is high and `ext_wdata` carries all 32 request bits one clock before `ext_wr_n` falls. The data stays driven for the whole strobe.
- R4: A strobe stays low for exactly N clocks. N is the value of `cfg_strobe_len` at the accepting edge, and a value of 0 counts as 1.
- R5: In a read, `ext_rd_n` is low for N clocks and `ext_wdata_en` stays low throughout. The two strobes are never low together.
- R6: Read data is sampled from `ext_rdata` on the clock edge that ends the last strobe clock.
- R7: One hold clock with both strobes high separates the rising strobe from the rising `ext_cs_n`. `ext_cs_n` is low for N+2 clocks per cycle, and the first of those clocks has both strobes high.
- R8: `rsp_valid` is high for exactly one clock, the clock in which `ext_cs_n` has just returned high. In that clock `rsp_rdata` holds the sampled word for reads and zero for writes.
- R9: `req_ready` is high only when no cycle is in progress. A request presented during a cycle waits and is accepted after the acknowledge, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strobe_len | input | 8 | Strobe length in clocks (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock acknowledge |
| rsp_rdata | output | 32 | Read data on acknowledge |
| ext_cs_n | output | 1 | Active-low region chip select |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_addr | output | 20 | Word address (byte bits 21:2) |
| ext_wdata | output | 32 | Data driven to the bus |
| ext_wdata_en | output | 1 | Data bus output enable, writes only |
| ext_rdata | input | 32 | Data returned from the bus |

## Verification
Writes and reads are mixed inside the region at strobe lengths 10, 3, 1 and 0. These runs separate a correct strobe counter from one that is off by one, and they show that the zero-to-one clamp takes effect. The external read model returns a poison word on every strobe clock except the last, so data sampled too early or too late cannot pass. Requests outside the region, and addresses with bits above 21 set, show that the decode and the address slicing are right. Back-to-back requests held during a busy cycle test the stall and the ordering of the acknowledges.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_ACK    = 3'd4
  } ebm_state_t;
endpackage

// File: rtl/ebm_region_dec.sv
module ebm_region_dec #(
  parameter int          AW    = 32,
  parameter logic [31:0] MASK  = 32'hF000_0000,
  parameter logic [31:0] MATCH = 32'hA000_0000
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  generate
    if (MASK == 32'h0) begin : g_all
      assign hit = 1'b1;
    end else begin : g_cmp
      assign hit = ((addr & MASK[AW-1:0]) == (MATCH[AW-1:0] & MASK[AW-1:0]));
    end
  endgenerate
endmodule

// File: rtl/ebm_strobe_timer.sv
module ebm_strobe_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             run,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= (len == '0) ? LEN_W'(1) : len;
    else if (run && !last) cnt <= cnt - LEN_W'(1);
  end

  assign last = (cnt == LEN_W'(1));

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)); // R4
endmodule

// File: rtl/ebm_rd_capture.sv
module ebm_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= '0;
    else if (cap) q <= din;
  end
endmodule

// File: rtl/ebm_bus_master.sv
module ebm_bus_master #(
  parameter int          AW     = 32,
  parameter int          DW     = 32,
  parameter int          XA_LO  = 2,
  parameter int          XA_HI  = 21,
  parameter int          LEN_W  = 8,
  parameter logic [31:0] R_MASK = 32'hF000_0000,
  parameter logic [31:0] R_BASE = 32'hA000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LEN_W-1:0]     cfg_strobe_len,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 ext_cs_n,
  output logic                 ext_wr_n,
  output logic                 ext_rd_n,
  output logic [XA_HI-XA_LO:0] ext_addr,
  output logic [DW-1:0]        ext_wdata,
  output logic                 ext_wdata_en,
  input  logic [DW-1:0]        ext_rdata
);
  import ebm_pkg::*;
  localparam int XAW = XA_HI - XA_LO + 1;

  ebm_state_t     state, state_nx;
  logic           hit, accept, last, is_wr, busy, in_strobe;
  logic [XAW-1:0] addr_q;
  logic [DW-1:0]  wdata_q;

  assign accept    = req_valid && (state == ST_IDLE);
  assign busy      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign in_strobe = (state == ST_STROBE);

  ebm_region_dec #(.AW(AW), .MASK(R_MASK), .MATCH(R_BASE)) u_dec (
    .addr(req_addr), .hit(hit));

  ebm_strobe_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk(clk), .rst(rst), .load(accept), .len(cfg_strobe_len),
    .run(in_strobe), .last(last));

  ebm_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .clear(accept),
    .cap(in_strobe && last && !is_wr), .din(ext_rdata), .q(rsp_rdata));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (req_valid) state_nx = hit ? ST_SETUP : ST_ACK;
      ST_SETUP:  state_nx = ST_STROBE;
      ST_STROBE: if (last) state_nx = ST_HOLD;
      ST_HOLD:   state_nx = ST_ACK;
      ST_ACK:    state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        is_wr   <= req_write;
        addr_q  <= req_addr[XA_HI:XA_LO];
        wdata_q <= req_wdata;
      end
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_ACK);
  assign ext_cs_n     = !busy;
  assign ext_wr_n     = !(in_strobe && is_wr);
  assign ext_rd_n     = !(in_strobe && !is_wr);
  assign ext_addr     = addr_q;
  assign ext_wdata    = wdata_q;
  assign ext_wdata_en = busy && is_wr;

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ext_wr_n && !ext_rd_n)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!ext_wr_n || !ext_rd_n) |-> !ext_cs_n); // R7
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_cs_n) |-> (ext_wr_n && ext_rd_n)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ext_cs_n && $past(!ext_cs_n)) |-> $stable(ext_addr)); // R2
  AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_cs_n) |-> rsp_valid); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_OE_READ_OFF: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_wdata_en); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ext_cs_n |-> !req_ready); // R9
endmodule

// File: tb/ebm_bus_master_test.sv
module ebm_bus_master_test;
  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] data;
    int          len;
  } item_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic [7:0]  cfg_strobe_len = 8'd10;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ext_cs_n, ext_wr_n, ext_rd_n, ext_wdata_en;
  logic [19:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;

  int checks = 0, fails = 0, cyc = 0, rd_run = 0;
  int cs_low = 0, wr_low = 0;
  bit saw_cs = 0, done = 0;
  logic p_cs_n = 1'b1, p_wr_n = 1'b1, p_oe = 1'b0;
  item_t q[$];

  always #4 clk = ~clk;

  ebm_bus_master uut (
    .clk(clk), .rst(rst), .cfg_strobe_len(cfg_strobe_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_cs_n(ext_cs_n), .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_wdata_en(ext_wdata_en),
    .ext_rdata(ext_rdata));

  function automatic logic [31:0] pat(logic [19:0] a);
    return {a, 12'h5A3} ^ 32'h1357_9BDF;
  endfunction

  function automatic int eff_len();
    return (cfg_strobe_len == 8'd0) ? 1 : int'(cfg_strobe_len);
  endfunction

  // Bus model: valid data only during the final strobe clock (R6)
  assign ext_rdata = (!ext_rd_n && q.size() > 0 && rd_run == q[0].len)
                     ? pat(ext_addr) : 32'hBAD0_BAD0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic issue(bit w, logic [31:0] a, logic [31:0] d);
    item_t it;
    it.wr = w; it.addr = a; it.data = d; it.len = eff_len();
    q.push_back(it);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      bit in_reg;
      in_reg = (q.size() > 0) && (q[0].addr[31:28] == 4'hA);
      if (!ext_cs_n) begin
        saw_cs = 1;
        chk(!req_ready, "R9 ready low while busy", {31'd0, req_ready}, 32'd0);
        if (q.size() > 0)
          chk(ext_addr == q[0].addr[21:2], "R2 address", {12'd0, ext_addr}, {12'd0, q[0].addr[21:2]});
      end
      if (!ext_wr_n && q.size() > 0) begin
        chk(ext_wdata_en && ext_wdata == q[0].data, "R3 write data", ext_wdata, q[0].data);
        if (p_wr_n)
          chk(!p_cs_n && p_oe, "R3 setup before strobe", {30'd0, p_cs_n, p_oe}, 32'd1);
      end
      if (!ext_rd_n)
        chk(!ext_wdata_en && ext_wr_n, "R5 read strobe alone", {30'd0, ext_wdata_en, ext_wr_n}, 32'd1);
      if (!ext_rd_n) rd_run <= rd_run + 1; else rd_run <= 0;
      if (!p_wr_n && ext_wr_n && q.size() > 0)
        chk(wr_low == q[0].len, "R4 write strobe width", wr_low, q[0].len);
      if (!ext_wr_n) wr_low++; else wr_low = 0;
      if (!p_cs_n && ext_cs_n && q.size() > 0)
        chk(cs_low == q[0].len + 2, "R7 chip select span", cs_low, q[0].len + 2);
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R8 unexpected ack", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          if (in_reg) begin
            chk(!p_cs_n && ext_cs_n, "R8 ack right after chip select rises", {31'd0, p_cs_n}, 32'd0);
            chk(rsp_rdata == (it.wr ? 32'd0 : pat(it.addr[21:2])),
                it.wr ? "R8 write rdata zero" : "R6 read data", rsp_rdata,
                it.wr ? 32'd0 : pat(it.addr[21:2]));
          end else begin
            chk(!saw_cs, "R1 no bus activity off region", {31'd0, saw_cs}, 32'd0);
            chk(rsp_rdata == 32'd0, "R1 off-region rdata", rsp_rdata, 32'd0);
          end
          saw_cs = 0;
        end
      end
      if (!ext_cs_n) cs_low++; else cs_low = 0;
      p_cs_n = ext_cs_n; p_wr_n = ext_wr_n; p_oe = ext_wdata_en;
    end
  end

  // Read strobe width (R5)
  int rd_low = 0;
  logic p_rd_n = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!p_rd_n && ext_rd_n && q.size() > 0)
        chk(rd_low == q[0].len, "R5 read strobe width", rd_low, q[0].len);
      if (!ext_rd_n) rd_low++; else rd_low = 0;
      p_rd_n = ext_rd_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ext_cs_n && ext_wr_n && ext_rd_n && !ext_wdata_en && !rsp_valid,
        "R9 reset pins idle", {27'd0, ext_cs_n, ext_wr_n, ext_rd_n, ext_wdata_en, rsp_valid}, 32'h1C);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", {31'd0, req_ready}, 32'd1);
    // R3 R4: default length writes
    issue(1, 32'hA03C_0010, 32'h0000_07FF);
    issue(1, 32'hA03C_0014, 32'h0017_D6DE);
    // R6 read
    issue(0, 32'hA03A_5678, 32'h0);
    // R1 off region
    issue(1, 32'h8000_0040, 32'hFFFF_FFFF);
    issue(0, 32'hB000_0000, 32'h0);
    // R2 upper bits discarded
    issue(0, 32'hAFFF_FFFC, 32'h0);
    drain();
    cfg_strobe_len = 8'd1;
    issue(0, 32'hA000_0004, 32'h0);
    issue(1, 32'hA012_3458, 32'hCAFE_F00D);
    drain();
    cfg_strobe_len = 8'd0;  // R4 clamp to one
    issue(1, 32'hA000_0100, 32'h1234_5678);
    issue(0, 32'hA000_0200, 32'h0);
    drain();
    cfg_strobe_len = 8'd3;  // R9 back to back with held valid
    issue(0, 32'hA003_0000, 32'h0);
    issue(1, 32'hA003_0004, 32'h8765_4321);
    issue(0, 32'h1000_0000, 32'h0);
    issue(0, 32'hA003_0008, 32'h0);
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule